// File: doc/BRIEF.md
# Capture/Compare Interval Timer

A 16-bit up-counter that advances by one on each cycle in which a count-enable strobe is high. It serves as a time base for four event channels. Two channels only compare. The other two can each be switched to capture the counter value when an external trigger edge arrives. A mode bit selects how the counter behaves. In interval mode the counter returns to zero after it reaches the value of compare channel 0, which sets the period. In free-running mode it wraps through the full 16-bit range, and each wrap records a sticky overflow flag.

Software reaches the block through a plain synchronous port. One address bus serves writes and combinational reads, and every register is one 16-bit word. Each channel drives its own one-cycle interrupt pulse. Typical uses are periodic interrupts, timestamps of external events, pulse-width measurement (capture on both edges) and period measurement (capture on a single edge).

Top module: `cc_interval_timer`

## Requirements
- R1: After reset the counter, every channel register, the control word and the overflow flag read as zero, and no interrupt is high.
- R2: Register addresses are 0 counter, 1 compare 0, 2 compare 1, 3 capture/compare 0, 4 capture/compare 1, 5 control, 6 status. Control bits: bit0 interval mode, bit1 channel-2 capture mode, bit2 channel-3 capture mode, bit3 channel-2 trigger source (0 = trig_a, 1 = trig_b), bits 5:4 edge select of trig_a, bits 7:6 edge select of trig_b. Status bit0 is the overflow flag.
- R3: In interval mode, a tick while the counter equals compare 0 loads 0, and the next tick loads 1, so the period is compare 0 + 1 ticks. With compare 0 = 0 the counter stays at 0 and the match fires on every tick.
- R4: In free-running mode the counter goes from 0xFFFF to 0x0000 on a tick. A compare-0 match does not clear it.
- R5: The overflow flag is set on a free-running wrap from 0xFFFF, and only in free-running mode. It stays set until a status write with bit0 = 1. A write with bit0 = 0 leaves it unchanged. A wrap in the same cycle as a clear leaves it set.
- R6: A tick during which the counter equals a compare value produces a one-cycle high on that channel's interrupt in the following cycle. Ticks that do not match produce no pulse.
- R7: A capture/compare channel in compare mode behaves exactly like a compare channel on irq_cc. In capture mode it produces no compare pulses.
- R8: In capture mode, a valid trigger edge copies the counter into the channel register and pulses irq_cc. The pulse and the new value appear three clock edges after the pin changes: two synchronizer stages plus the edge register.
- R9: Edge select: 00 ignores the input, 01 accepts rising edges, 10 accepts falling edges, 11 accepts both.
- R10: Channel 2 takes its trigger from trig_a or trig_b according to control bit3. Channel 3 always takes trig_a and ignores trig_b.
- R11: A write to the counter takes priority over a tick in the same cycle.
- R12: A capture overrides a software write to the same channel register in the same cycle. A channel in compare mode ignores trigger edges.
- R13: A capture on one channel and a compare match on another in the same cycle are both handled, each on its own interrupt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count-enable strobe, one count per high cycle |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| trig_a | input | 1 | External trigger A (asynchronous) |
| trig_b | input | 1 | External trigger B (asynchronous) |
| irq_cmp | output | 2 | Match pulses of the two compare channels |
| irq_cc | output | 2 | Match or capture pulses of the two capture/compare channels |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
A table of counter scenarios is run in both modes. It uses compare values one tick before, at and one tick after the match, plus compare 0 = 0 and 0xFFFF, and wraps starting from 0xFFFE. These cases separate clear-on-match from plain counting, and separate a wrap that sets the flag from one that does not. Trigger sequences then drive rising and falling transitions on each input under every edge-select code. They show which transitions capture, which channel each input reaches, and whether a channel in compare mode ignores them. Directed cases line up collisions: a counter write against a tick, a status clear against a wrap, a capture against a register write, and a capture against a compare match.

// File: rtl/cct_pkg.sv
package cct_pkg;
    localparam int OFS_COUNT = 0;
    localparam int OFS_CMP0  = 1;
    localparam int OFS_CMP1  = 2;
    localparam int OFS_CC0   = 3;
    localparam int OFS_CC1   = 4;
    localparam int OFS_CTRL  = 5;
    localparam int OFS_STAT  = 6;

    localparam int NUM_TRIG  = 2;
    localparam int NUM_CH    = 4;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    // packed from MSB down: interval ends up in bit 0
    typedef struct packed {
        edge_sel_e edge_b;
        edge_sel_e edge_a;
        logic      cc0_src_b;
        logic      cc1_cap;
        logic      cc0_cap;
        logic      interval;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/cct_trig_edge.sv
module cct_trig_edge
    import cct_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_sel_e sel,
    output logic      hit
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_t;

    sync_t st_d, st_q;
    logic  rise, fall;
    logic [1:0] sel_bits;

    always_comb begin
        st_d.s1   = pin;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
        sel_bits  = sel;
        rise      = st_q.s2 & ~st_q.prev;
        fall      = ~st_q.s2 & st_q.prev;
        hit       = (sel_bits[0] & rise) | (sel_bits[1] & fall);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         interval,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic [W-1:0] cmp0,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output logic         ovf
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         ovf;
    } cnt_st_t;

    cnt_st_t st_d, st_q;
    logic    wrap;

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            if (interval && (st_q.cnt == cmp0)) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
                wrap     = !interval && (st_q.cnt == CNT_MAX);
            end
        end
        if (ovf_clr) st_d.ovf = 1'b0;
        if (wrap)    st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign ovf = st_q.ovf;
endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic [W-1:0] cnt,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         cap_mode,
    input  logic         trig_hit,
    output logic [W-1:0] val,
    output logic         irq
);
    typedef struct packed {
        logic [W-1:0] val;
        logic         irq;
    } ch_st_t;

    ch_st_t st_d, st_q;
    logic   cap_ev;
    logic   cmp_ev;

    always_comb begin
        cap_ev   = cap_mode && trig_hit;
        cmp_ev   = !cap_mode && tick && (cnt == st_q.val);
        st_d.val = st_q.val;
        if (cap_ev)  st_d.val = cnt;
        else if (wr) st_d.val = wdata;
        st_d.irq = cap_ev || cmp_ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign val = st_q.val;
    assign irq = st_q.irq;
endmodule

// File: rtl/cc_interval_timer.sv
module cc_interval_timer
    import cct_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  wdata,
    output logic [CNT_W-1:0]  rdata,
    input  logic              trig_a,
    input  logic              trig_b,
    output logic [1:0]        irq_cmp,
    output logic [1:0]        irq_cc,
    output logic              ovf_flag
);
    localparam logic [ADDR_W-1:0] AD_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] AD_CMP0  = ADDR_W'(OFS_CMP0);
    localparam logic [ADDR_W-1:0] AD_CMP1  = ADDR_W'(OFS_CMP1);
    localparam logic [ADDR_W-1:0] AD_CC0   = ADDR_W'(OFS_CC0);
    localparam logic [ADDR_W-1:0] AD_CC1   = ADDR_W'(OFS_CC1);
    localparam logic [ADDR_W-1:0] AD_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] AD_STAT  = ADDR_W'(OFS_STAT);

    // control register, two-process
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && addr == AD_CTRL) ctrl_d = ctrl_t'(wdata[CTRL_W-1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    // trigger synchronizers and edge qualifiers
    logic [NUM_TRIG-1:0] trig_pin;
    logic [NUM_TRIG-1:0] trig_hit;
    edge_sel_e           trig_sel [NUM_TRIG];

    always_comb begin
        trig_pin    = {trig_b, trig_a};
        trig_sel[0] = ctrl_q.edge_a;
        trig_sel[1] = ctrl_q.edge_b;
    end

    for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
        cct_trig_edge u_edge (
            .clk   (clk),
            .rst_n (rst_n),
            .pin   (trig_pin[t]),
            .sel   (trig_sel[t]),
            .hit   (trig_hit[t])
        );
    end

    // counter
    logic [CNT_W-1:0] cnt_q;
    logic             ovf_q;
    logic [CNT_W-1:0] ch_val [NUM_CH];
    logic             cnt_load;
    logic             ovf_clr;

    always_comb begin
        cnt_load = wr_en && (addr == AD_COUNT);
        ovf_clr  = wr_en && (addr == AD_STAT) && wdata[0];
    end

    cct_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .interval (ctrl_q.interval),
        .load     (cnt_load),
        .load_val (wdata),
        .cmp0     (ch_val[0]),
        .ovf_clr  (ovf_clr),
        .cnt      (cnt_q),
        .ovf      (ovf_q)
    );

    // channels: 0,1 compare only; 2,3 capture/compare
    logic [NUM_CH-1:0] cap_mode;
    logic [NUM_CH-1:0] cap_trig;
    logic [NUM_CH-1:0] ch_irq;

    always_comb begin
        cap_mode = {ctrl_q.cc1_cap, ctrl_q.cc0_cap, 2'b00};
        cap_trig = {trig_hit[0], (ctrl_q.cc0_src_b ? trig_hit[1] : trig_hit[0]), 2'b00};
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_AD = ADDR_W'(OFS_CMP0 + ch);
        cct_channel #(.W(CNT_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .cnt      (cnt_q),
            .wr       (wr_en && (addr == CH_AD)),
            .wdata    (wdata),
            .cap_mode (cap_mode[ch]),
            .trig_hit (cap_trig[ch]),
            .val      (ch_val[ch]),
            .irq      (ch_irq[ch])
        );
    end

    // read mux
    always_comb begin
        case (addr)
            AD_COUNT: rdata = cnt_q;
            AD_CMP0:  rdata = ch_val[0];
            AD_CMP1:  rdata = ch_val[1];
            AD_CC0:   rdata = ch_val[2];
            AD_CC1:   rdata = ch_val[3];
            AD_CTRL:  rdata = CNT_W'(ctrl_q);
            AD_STAT:  rdata = CNT_W'(ovf_q);
            default:  rdata = '0;
        endcase
    end

    assign irq_cmp  = ch_irq[1:0];
    assign irq_cc   = ch_irq[3:2];
    assign ovf_flag = ovf_q;
endmodule

// File: rtl/cct_checker.sv
module cct_checker
    import cct_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  wdata,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  cmp0,
    input logic [CNT_W-1:0]  cmp1,
    input logic              interval,
    input logic              ovf,
    input logic              irq_cmp1
);
    logic wr_cnt, wr_clr;
    assign wr_cnt = wr_en && (addr == ADDR_W'(OFS_COUNT));
    assign wr_clr = wr_en && (addr == ADDR_W'(OFS_STAT)) && wdata[0];

    // R3
    a_r3_interval_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (interval && tick && cnt == cmp0 && !wr_cnt) |=> (cnt == '0));

    // R4
    a_r4_free_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (!interval && tick && cnt == {CNT_W{1'b1}} && !wr_cnt) |=> (cnt == '0 && ovf));

    // R5
    a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !wr_clr) |=> ovf);

    // R11
    a_r11_write_prio: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt == $past(wdata)));

    // R6
    a_r6_match_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == cmp1) |=> irq_cmp1);

    // R6
    a_r6_no_tick_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> !irq_cmp1);
endmodule

bind cc_interval_timer cct_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_en    (wr_en),
    .addr     (addr),
    .wdata    (wdata),
    .cnt      (cnt_q),
    .cmp0     (ch_val[0]),
    .cmp1     (ch_val[1]),
    .interval (ctrl_q.interval),
    .ovf      (ovf_q),
    .irq_cmp1 (irq_cmp[1])
);

// File: tb/cc_interval_timer_test.sv
module cc_interval_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] rdata;
    logic        trig_a = 1'b0;
    logic        trig_b = 1'b0;
    logic [1:0]  irq_cmp;
    logic [1:0]  irq_cc;
    logic        ovf_flag;

    int total = 0;
    int bad = 0;

    localparam logic [2:0] RA_CNT = 3'd0, RA_C0 = 3'd1, RA_C1 = 3'd2,
                           RA_CC0 = 3'd3, RA_CC1 = 3'd4, RA_CTL = 3'd5, RA_ST = 3'd6;

    always #10 clk = ~clk;

    cc_interval_timer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .trig_a(trig_a), .trig_b(trig_b),
        .irq_cmp(irq_cmp), .irq_cc(irq_cc), .ovf_flag(ovf_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    // wait three edges after a pin change (caller at a negedge)
    task automatic sync_wait();
        repeat (3) @(negedge clk);
    endtask

    typedef struct packed {
        logic        intv;
        logic [15:0] cmp;
        logic [15:0] load;
        logic [7:0]  n;
        logic [15:0] exp_cnt;
        logic        exp_irq;
        logic        exp_ovf;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 16'd5,      16'd0,      8'd5, 16'd5,      1'b0, 1'b0}, // R3 before match
        '{1'b1, 16'd5,      16'd0,      8'd6, 16'd0,      1'b1, 1'b0}, // R3 clear
        '{1'b1, 16'd5,      16'd0,      8'd7, 16'd1,      1'b0, 1'b0}, // R3 restart
        '{1'b0, 16'd5,      16'd0,      8'd6, 16'd6,      1'b1, 1'b0}, // R4 no clear
        '{1'b1, 16'd0,      16'd0,      8'd1, 16'd0,      1'b1, 1'b0}, // R3 cmp0=0
        '{1'b0, 16'd3,      16'hFFFE,   8'd2, 16'd0,      1'b0, 1'b1}, // R4/R5 wrap
        '{1'b1, 16'd3,      16'd10,     8'd2, 16'd12,     1'b0, 1'b0}, // R3 past compare
        '{1'b1, 16'hFFFF,   16'hFFFE,   8'd2, 16'd0,      1'b1, 1'b0}  // R5 no flag in interval
    };

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 7; a++) begin
            rd(3'(a), v);
            chk("R1 reset reg", {16'd0, v}, 32'd0);
        end
        chk("R1 irq", {28'd0, irq_cmp, irq_cc}, 32'd0);
        chk("R1 ovf", {31'd0, ovf_flag}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        rd(RA_CNT, v);
        chk("R1 no tick no count", {16'd0, v}, 32'd0);

        // R2 control readback
        wr(RA_CTL, 16'h00A5);
        rd(RA_CTL, v);
        chk("R2 ctrl readback", {16'd0, v}, 32'h00A5);

        // table walk: R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            logic irq_seen;
            wr(RA_CTL, {15'd0, VEC[i].intv});
            wr(RA_C0, VEC[i].cmp);
            wr(RA_CNT, VEC[i].load);
            wr(RA_ST, 16'd1);
            ticks(int'(VEC[i].n));
            irq_seen = irq_cmp[0];
            chk("R6 vector irq_cmp0", {31'd0, irq_seen}, {31'd0, VEC[i].exp_irq});
            rd(RA_CNT, v);
            chk("R3/R4 vector count", {16'd0, v}, {16'd0, VEC[i].exp_cnt});
            chk("R5 vector ovf", {31'd0, ovf_flag}, {31'd0, VEC[i].exp_ovf});
        end

        // R5 sticky and write-one-to-clear
        wr(RA_CTL, 16'h0000);
        wr(RA_CNT, 16'hFFFF);
        ticks(1);
        ticks(3);
        chk("R5 sticky", {31'd0, ovf_flag}, 32'd1);
        wr(RA_ST, 16'd0);
        chk("R5 write zero keeps", {31'd0, ovf_flag}, 32'd1);
        wr(RA_ST, 16'd1);
        chk("R5 write one clears", {31'd0, ovf_flag}, 32'd0);
        // R5 set wins over clear
        wr(RA_CNT, 16'hFFFF);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = RA_ST; wdata = 16'd1;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        chk("R5 set beats clear", {31'd0, ovf_flag}, 32'd1);
        wr(RA_ST, 16'd1);

        // R6 compare channel 1, R7 cc compare mode
        wr(RA_CTL, 16'h0000);
        wr(RA_C0, 16'h7000);
        wr(RA_C1, 16'd3);
        wr(RA_CC0, 16'd2);
        wr(RA_CC1, 16'd5);
        wr(RA_CNT, 16'd0);
        ticks(2);
        chk("R6 no early pulse cmp1", {31'd0, irq_cmp[1]}, 32'd0);
        ticks(1);
        chk("R7 cc0 compare match", {31'd0, irq_cc[0]}, 32'd1);
        ticks(1);
        chk("R6 cmp1 match", {31'd0, irq_cmp[1]}, 32'd1);
        @(negedge clk);
        chk("R6 single pulse", {31'd0, irq_cmp[1]}, 32'd0);
        ticks(2);
        chk("R7 cc1 compare match", {31'd0, irq_cc[1]}, 32'd1);
        // R7 capture mode suppresses compare
        wr(RA_CTL, 16'h0002);
        wr(RA_CNT, 16'd0);
        ticks(3);
        chk("R7 capture mode no match", {31'd0, irq_cc[0]}, 32'd0);

        // R8 R9 rising only on trig_a for cc0
        wr(RA_CTL, 16'h0012);
        wr(RA_CNT, 16'h1234);
        trig_a = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 no early capture", {31'd0, irq_cc[0]}, 32'd0);
        @(negedge clk);
        chk("R8 capture irq", {31'd0, irq_cc[0]}, 32'd1);
        rd(RA_CC0, v);
        chk("R8 captured value", {16'd0, v}, 32'h1234);
        @(negedge clk);
        chk("R8 irq single", {31'd0, irq_cc[0]}, 32'd0);
        wr(RA_CNT, 16'h2222);
        trig_a = 1'b0;
        begin
            logic any;
            any = 1'b0;
            repeat (4) begin @(negedge clk); any |= irq_cc[0]; end
            chk("R9 rising ignores fall", {31'd0, any}, 32'd0);
        end
        rd(RA_CC0, v);
        chk("R9 value kept", {16'd0, v}, 32'h1234);

        // R9 R10 falling only on trig_b for cc0
        wr(RA_CTL, 16'h008A);
        wr(RA_CNT, 16'h0444);
        trig_b = 1'b1;
        sync_wait();
        chk("R9 falling ignores rise", {31'd0, irq_cc[0]}, 32'd0);
        trig_b = 1'b0;
        sync_wait();
        chk("R10 cc0 from trig_b", {31'd0, irq_cc[0]}, 32'd1);
        rd(RA_CC0, v);
        chk("R10 cc0 value", {16'd0, v}, 32'h0444);

        // R9 edge off
        wr(RA_CTL, 16'h0002);
        wr(RA_CNT, 16'h0999);
        trig_a = 1'b1;
        sync_wait();
        chk("R9 off ignores edge", {31'd0, irq_cc[0]}, 32'd0);
        trig_a = 1'b0;
        sync_wait();
        rd(RA_CC0, v);
        chk("R9 off value kept", {16'd0, v}, 32'h0444);

        // R10 cc1 uses trig_a only, R9 both edges
        wr(RA_CTL, 16'h00F4);
        wr(RA_CC1, 16'hAAAA);
        wr(RA_CNT, 16'h0055);
        trig_b = 1'b1;
        sync_wait();
        chk("R10 cc1 ignores trig_b", {31'd0, irq_cc[1]}, 32'd0);
        rd(RA_CC1, v);
        chk("R10 cc1 unchanged", {16'd0, v}, 32'hAAAA);
        trig_a = 1'b1;
        sync_wait();
        chk("R9 both rise", {31'd0, irq_cc[1]}, 32'd1);
        wr(RA_CNT, 16'h0066);
        trig_a = 1'b0;
        sync_wait();
        chk("R9 both fall", {31'd0, irq_cc[1]}, 32'd1);
        rd(RA_CC1, v);
        chk("R9 both fall value", {16'd0, v}, 32'h0066);
        trig_b = 1'b0;

        // R12 compare mode ignores trigger
        wr(RA_CTL, 16'h0030);
        wr(RA_CC0, 16'h5151);
        trig_a = 1'b1;
        sync_wait();
        rd(RA_CC0, v);
        chk("R12 compare mode ignores trig", {16'd0, v}, 32'h5151);
        trig_a = 1'b0;
        sync_wait();

        // R12 capture beats write
        wr(RA_CTL, 16'h0012);
        wr(RA_CNT, 16'h0777);
        trig_a = 1'b1;
        repeat (2) @(negedge clk);
        wr_en = 1'b1; addr = RA_CC0; wdata = 16'h9999;
        @(negedge clk);
        wr_en = 1'b0;
        rd(RA_CC0, v);
        chk("R12 capture over write", {16'd0, v}, 32'h0777);
        trig_a = 1'b0;
        sync_wait();

        // R11 write beats tick
        wr(RA_CTL, 16'h0000);
        wr(RA_CNT, 16'h0100);
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; addr = RA_CNT; wdata = 16'h0200;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(RA_CNT, v);
        chk("R11 write priority", {16'd0, v}, 32'h0200);

        // R13 capture on cc1 with cmp0 clear in same cycle
        wr(RA_CTL, 16'h0035);
        wr(RA_C0, 16'd7);
        wr(RA_CNT, 16'd7);
        trig_a = 1'b1;
        repeat (2) @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R13 cmp0 irq", {31'd0, irq_cmp[0]}, 32'd1);
        chk("R13 cc1 irq", {31'd0, irq_cc[1]}, 32'd1);
        rd(RA_CC1, v);
        chk("R13 cc1 value", {16'd0, v}, 32'd7);
        rd(RA_CNT, v);
        chk("R13 counter cleared", {16'd0, v}, 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule